// File: doc/BRIEF.md
# DMA Channel Start and Bus-Hold Sequencer

This block decides, cycle by cycle, whether a small multi-channel DMA engine may issue its next bus beat and for which channel. It combines a global enable, one enable per channel, a temporary-stop (pause) input and an external bus-hold handshake. Requests from enabled channels are recorded as pending flags. Each accepted request launches a burst of `BEATS` single-cycle beats. The burst owns the engine until its last beat, until its channel is disabled, or until the global enable is cleared.

Each channel carries a flag that marks its target as the external bus area or an internal area. An external hold request stalls only the channels whose target is external. Internal channels keep transferring while the hold is acknowledged. The acknowledge is withheld until any external burst already in progress has finished. The address and count datapath and the real bus protocol are handled elsewhere. This block only produces the grant, its channel index and its area tag.

Top module: `dma_gate_seq`

## Requirements
- R1: While `glb_en` is 0 no grant is issued and no request is recorded. A request presented while `glb_en` is 0 leaves no pending flag after `glb_en` is set.
- R2: A request on `req[i]` is recorded only while `glb_en` and `ch_en[i]` are both 1. It appears on `pend[i]` after the next clock edge.
- R3: While `pause` is 1 no grant is issued. Pending flags and an unfinished burst are kept, and serving resumes in the first cycle after `pause` returns to 0.
- R4: `hold_ack` rises on the edge after a cycle in which `hold_req` is 1 and no external-area burst is running. It falls on the edge after a cycle in which `hold_req` is 0.
- R5: While `hold_req` or `hold_ack` is 1, no burst may start on a channel with `ext_area[i]`=1 (1 means external, 0 means internal). Channels with `ext_area[i]`=0 are still granted. When a request and a hold request arrive together, the hold is acknowledged and the internal channel is served during the hold.
- R6: `hold_ack` is never 1 in the cycle after a beat with `gnt_ext`=1. A hold that arrives during an external burst is acknowledged only after that burst's last beat.
- R7: When several eligible channels are pending, the lowest-numbered channel is started. At most one grant is issued per cycle. `gnt_ch` is the binary channel index, and `gnt_ch` and `gnt_ext` are 0 when `gnt_vld` is 0.
- R8: A started channel receives `BEATS` grants, one per unblocked cycle. The first grant comes from its pending flag, which clears on that edge. `busy[i]` is 1 in the cycles after the first grant until the burst ends, and no other channel starts meanwhile.
- R9: Clearing `glb_en` clears every pending flag and ends any burst at the next edge. Clearing `ch_en[i]` blocks channel i at once and clears only channel i's pending flag and burst.
- R10: While `rst_n` is 0 all pending flags, busy flags, the grant and `hold_ack` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global DMA operation enable |
| ch_en | input | N_CH | Per-channel operation enable |
| pause | input | 1 | Temporary stop for all channels |
| hold_req | input | 1 | External bus hold request |
| req | input | N_CH | Per-channel transfer request |
| ext_area | input | N_CH | 1: channel targets the external bus area |
| gnt_vld | output | 1 | A beat is issued this cycle |
| gnt_ch | output | CH_W | Index of the granted channel |
| gnt_ext | output | 1 | Granted beat targets the external area |
| hold_ack | output | 1 | External hold acknowledge |
| pend | output | N_CH | Per-channel pending request flags |
| busy | output | N_CH | Per-channel burst-in-progress flags |

## Verification
The bench builds the block with four channels and three-beat bursts. Three beats is long enough for a burst to be caught part-way by a pause, a hold request or a channel disable. Channels 2 and 3 are external and channels 0 and 1 are internal. This lets one run show internal bursts continuing under a hold, an external burst delaying the acknowledge, and lowest-index priority among mixed pending sets.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
   typedef enum logic {
      HOLD_OFF = 1'b0,
      HOLD_ON  = 1'b1
   } hold_state_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/dma_lowest_pick.sv
module dma_lowest_pick #(
   parameter int unsigned N    = 4,
   parameter int unsigned IDXW = 2
) (
   input  logic [N-1:0]    cand,
   output logic [N-1:0]    hit,
   output logic            any,
   output logic [IDXW-1:0] idx
);
   logic [N:0] seen;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign hit[i]    = cand[i] & ~seen[i];
      assign seen[i+1] = seen[i] | cand[i];
   end

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int unsigned k = 0; k < N; k++) begin
         if (hit[k]) idx = IDXW'(k);
      end
   end
endmodule

// File: rtl/dma_req_bank.sv
module dma_req_bank #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         glb_en,
   input  logic [N-1:0] ch_en,
   input  logic [N-1:0] req,
   input  logic [N-1:0] take,
   output logic [N-1:0] pend
);
   for (genvar i = 0; i < N; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend[i] <= 1'b0;
         end else if (!glb_en || !ch_en[i]) begin
            pend[i] <= 1'b0;
         end else begin
            pend[i] <= (pend[i] & ~take[i]) | req[i];
         end
      end
   end
endmodule

// File: rtl/dma_burst_track.sv
module dma_burst_track
   import dma_seq_pkg::*;
#(
   parameter int unsigned N     = 4,
   parameter int unsigned IDXW  = 2,
   parameter int unsigned BEATS = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            glb_en,
   input  logic [N-1:0]    ch_en,
   input  logic            pause,
   input  logic            hold_req,
   input  logic            start,
   input  logic [IDXW-1:0] start_ch,
   input  logic            start_ext,
   output logic            act_vld,
   output logic [IDXW-1:0] act_ch,
   output logic            act_ext,
   output logic            beat_go,
   output logic            hold_ack
);
   localparam int unsigned CNTW = $clog2(BEATS + 1);

   hold_state_e hold_q;
   logic        ch_live;

   assign ch_live  = glb_en & ch_en[act_ch];
   assign hold_ack = (hold_q == HOLD_ON);
   assign beat_go  = act_vld & ch_live & ~pause & ~(act_ext & hold_ack);

   if (BEATS > 1) begin : g_multi
      logic [CNTW-1:0] left_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_vld <= 1'b0;
            act_ch  <= '0;
            act_ext <= 1'b0;
            left_q  <= '0;
         end else if (act_vld) begin
            if (!ch_live) begin
               act_vld <= 1'b0;
            end else if (beat_go) begin
               if (left_q == CNTW'(1)) act_vld <= 1'b0;
               left_q <= left_q - CNTW'(1);
            end
         end else if (start) begin
            act_vld <= 1'b1;
            act_ch  <= start_ch;
            act_ext <= start_ext;
            left_q  <= CNTW'(BEATS - 1);
         end
      end
   end else begin : g_single
      logic unused_start;
      assign unused_start = start ^ start_ext ^ (^start_ch);
      assign act_vld = 1'b0;
      assign act_ch  = '0;
      assign act_ext = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= HOLD_OFF;
      end else if (!hold_req) begin
         hold_q <= HOLD_OFF;
      end else if (!(act_vld && act_ext)) begin
         hold_q <= HOLD_ON;
      end
   end
endmodule

// File: rtl/dma_gate_seq.sv
module dma_gate_seq #(
   parameter int unsigned N_CH  = 4,
   parameter int unsigned BEATS = 4,
   parameter int unsigned CH_W  = dma_seq_pkg::idx_width(N_CH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            glb_en,
   input  logic [N_CH-1:0] ch_en,
   input  logic            pause,
   input  logic            hold_req,
   input  logic [N_CH-1:0] req,
   input  logic [N_CH-1:0] ext_area,
   output logic            gnt_vld,
   output logic [CH_W-1:0] gnt_ch,
   output logic            gnt_ext,
   output logic            hold_ack,
   output logic [N_CH-1:0] pend,
   output logic [N_CH-1:0] busy
);
   if (N_CH < 2 || N_CH > 64) begin : g_bad_nch
      $error("dma_gate_seq: N_CH must lie in 2..64");
   end
   if (BEATS < 1) begin : g_bad_beats
      $error("dma_gate_seq: BEATS must be at least 1");
   end
   if (CH_W < $clog2(N_CH)) begin : g_bad_chw
      $error("dma_gate_seq: CH_W too narrow for N_CH");
   end

   logic [N_CH-1:0] take;
   logic [N_CH-1:0] start_cand;
   logic [N_CH-1:0] ext_block;
   logic            start;
   logic [CH_W-1:0] start_ch;
   logic            act_vld;
   logic [CH_W-1:0] act_ch;
   logic            act_ext;
   logic            beat_go;
   logic            start_open;

   assign ext_block  = ext_area & {N_CH{hold_req | hold_ack}};
   assign start_open = glb_en & ~pause & ~act_vld;
   assign start_cand = pend & ch_en & ~ext_block & {N_CH{start_open}};

   dma_req_bank #(.N(N_CH)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .glb_en (glb_en),
      .ch_en  (ch_en),
      .req    (req),
      .take   (take),
      .pend   (pend)
   );

   dma_lowest_pick #(.N(N_CH), .IDXW(CH_W)) u_pick (
      .cand (start_cand),
      .hit  (take),
      .any  (start),
      .idx  (start_ch)
   );

   dma_burst_track #(.N(N_CH), .IDXW(CH_W), .BEATS(BEATS)) u_burst (
      .clk       (clk),
      .rst_n     (rst_n),
      .glb_en    (glb_en),
      .ch_en     (ch_en),
      .pause     (pause),
      .hold_req  (hold_req),
      .start     (start),
      .start_ch  (start_ch),
      .start_ext (ext_area[start_ch]),
      .act_vld   (act_vld),
      .act_ch    (act_ch),
      .act_ext   (act_ext),
      .beat_go   (beat_go),
      .hold_ack  (hold_ack)
   );

   assign gnt_vld = start | beat_go;

   always_comb begin
      gnt_ch  = '0;
      gnt_ext = 1'b0;
      if (beat_go) begin
         gnt_ch  = act_ch;
         gnt_ext = act_ext;
      end else if (start) begin
         gnt_ch  = start_ch;
         gnt_ext = ext_area[start_ch];
      end
   end

   for (genvar i = 0; i < N_CH; i++) begin : g_busy
      assign busy[i] = act_vld & (act_ch == CH_W'(i));
   end
endmodule

// File: rtl/dma_gate_seq_chk.sv
module dma_gate_seq_chk #(
   parameter int unsigned N_CH = 4,
   parameter int unsigned CH_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            glb_en,
   input logic            pause,
   input logic            hold_req,
   input logic            gnt_vld,
   input logic [CH_W-1:0] gnt_ch,
   input logic            gnt_ext,
   input logic            hold_ack,
   input logic [N_CH-1:0] pend,
   input logic [N_CH-1:0] busy
);
   assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |-> !gnt_vld);

   assert_pause_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pause |-> !gnt_vld);

   assert_ack_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_req |=> !hold_ack);

   assert_ack_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_ack) |-> $past(hold_req));

   assert_ext_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack |-> !(gnt_vld && gnt_ext));

   assert_ack_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_vld && gnt_ext) |=> !hold_ack);

   assert_grant_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld |-> (busy[gnt_ch] || pend[gnt_ch]));

   assert_one_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(busy));

   assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |=> (pend == '0 && busy == '0));
endmodule

bind dma_gate_seq dma_gate_seq_chk #(.N_CH(N_CH), .CH_W(CH_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .glb_en   (glb_en),
   .pause    (pause),
   .hold_req (hold_req),
   .gnt_vld  (gnt_vld),
   .gnt_ch   (gnt_ch),
   .gnt_ext  (gnt_ext),
   .hold_ack (hold_ack),
   .pend     (pend),
   .busy     (busy)
);

// File: tb/sim_dma_gate_seq.sv
module sim_dma_gate_seq;
   localparam int unsigned NC   = 4;
   localparam int unsigned NB   = 3;
   localparam int unsigned CW   = 2;
   localparam int unsigned ROWS = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          glb_en = 1'b0;
   logic [NC-1:0] ch_en = '0;
   logic          pause = 1'b0;
   logic          hold_req = 1'b0;
   logic [NC-1:0] req = '0;
   logic [NC-1:0] ext_area = 4'b1100;
   logic          gnt_vld;
   logic [CW-1:0] gnt_ch;
   logic          gnt_ext;
   logic          hold_ack;
   logic [NC-1:0] pend;
   logic [NC-1:0] busy;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dma_gate_seq #(.N_CH(NC), .BEATS(NB), .CH_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .ch_en(ch_en),
      .pause(pause), .hold_req(hold_req), .req(req), .ext_area(ext_area),
      .gnt_vld(gnt_vld), .gnt_ch(gnt_ch), .gnt_ext(gnt_ext),
      .hold_ack(hold_ack), .pend(pend), .busy(busy)
   );

   // row: {glb, ch_en[4], pause, hold, req[4]} , {gv, gch[2], gx, ack, pend[4], busy[4]}
   localparam logic [23:0] TABLE [ROWS] = '{
      {11'b0_1111_0_0_0001, 13'b0_00_0_0_0000_0000}, // R1 request before enable
      {11'b1_1111_0_0_0000, 13'b0_00_0_0_0000_0000}, // R1 discarded
      {11'b1_1111_0_0_0101, 13'b0_00_0_0_0000_0000}, // R2 sampled
      {11'b1_1111_0_0_0000, 13'b1_00_0_0_0101_0000}, // R7 lowest first
      {11'b1_1111_0_0_0000, 13'b1_00_0_0_0100_0001}, // R8 beat 2
      {11'b1_1111_0_0_0000, 13'b1_00_0_0_0100_0001}, // R8 beat 3
      {11'b1_1111_0_1_0000, 13'b0_00_0_0_0100_0000}, // R5 ext blocked by req
      {11'b1_1111_0_1_0010, 13'b0_00_0_1_0100_0000}, // R4 ack rises
      {11'b1_1111_0_1_0000, 13'b1_01_0_1_0110_0000}, // R5 internal under hold
      {11'b1_1111_0_1_0000, 13'b1_01_0_1_0100_0010}, // R8
      {11'b1_1111_0_0_0000, 13'b1_01_0_1_0100_0010}, // R4 ack still up
      {11'b1_1111_0_0_0000, 13'b1_10_1_0_0100_0000}, // R5 ext resumes
      {11'b1_1111_0_1_0000, 13'b1_10_1_0_0000_0100}, // R6 hold mid ext burst
      {11'b1_1111_0_1_0000, 13'b1_10_1_0_0000_0100}, // R6 no ack yet
      {11'b1_1111_0_1_0000, 13'b0_00_0_0_0000_0000}, // R6 boundary
      {11'b1_1111_1_0_1000, 13'b0_00_0_1_0000_0000}, // R3 request in pause
      {11'b1_1111_1_0_0000, 13'b0_00_0_0_1000_0000}, // R3 kept pending
      {11'b1_1111_0_0_0000, 13'b1_11_1_0_1000_0000}, // R3 served after release
      {11'b1_1111_1_0_0000, 13'b0_00_0_0_0000_1000}, // R3 burst paused
      {11'b1_0111_0_0_0000, 13'b0_00_0_0_0000_1000}, // R9 channel disabled
      {11'b1_1111_0_0_0110, 13'b0_00_0_0_0000_0000}, // R9 burst aborted
      {11'b1_1111_0_0_0000, 13'b1_01_0_0_0110_0000}, // R7 ch1 before ch2
      {11'b0_1111_0_0_0000, 13'b0_00_0_0_0100_0010}, // R9 global off
      {11'b1_1111_0_0_0000, 13'b0_00_0_0_0000_0000}  // R9 all cleared
   };

   function automatic logic [12:0] outs();
      return {gnt_vld, gnt_ch, gnt_ext, hold_ack, pend, busy};
   endfunction

   task automatic chk(input string tag, input logic [12:0] got, input logic [12:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%b expected=%b (gv gch gx ack pend busy)", tag, got, exp);
      end
   endtask

   task automatic drive(input logic [10:0] v);
      @(negedge clk);
      {glb_en, ch_en, pause, hold_req, req} = v;
      #2;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      {glb_en, ch_en, pause, hold_req, req} = '0;
      #2;
      chk("R10 reset state", outs(), 13'b0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      for (int r = 0; r < ROWS; r++) begin
         drive(TABLE[r][23:13]);
         chk($sformatf("table row %0d", r), outs(), TABLE[r][12:0]);
      end

      // R10: reset in the middle of activity
      drive(11'b1_1111_0_1_1111);
      drive(11'b1_1111_0_1_0000);
      do_reset();

      // R5 simultaneous request and hold: hold acked, internal ch1 proceeds
      drive(11'b1_1111_0_1_0110);
      chk("R5 simultaneous arrival", outs(), 13'b0_00_0_0_0000_0000);
      drive(11'b1_1111_0_1_0000);
      chk("R5 internal starts with hold", outs(), 13'b1_01_0_1_0110_0000);
      drive(11'b1_1111_0_1_0000);
      drive(11'b1_1111_0_1_0000);
      drive(11'b1_1111_0_1_0000);
      chk("R5 external waits for release", outs(), 13'b0_00_0_1_0100_0000);
      drive(11'b1_1111_0_0_0000);
      chk("R4 ack held one cycle", outs(), 13'b0_00_0_1_0100_0000);
      drive(11'b1_1111_0_0_0000);
      chk("R5 external starts after release", outs(), 13'b1_10_1_0_0100_0000);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule